// File: doc/BRIEF.md
# Windowed Configuration Space Mapper

This block serves the older of the two configuration access schemes. The host I/O bus reaches it with 1, 2 or 4 byte accesses, and it holds two byte-wide control registers. The first is the key register. Its upper nibble acts as a key that opens the mapped window, and bits 3:1 give the function number. The second is the bus register, which holds the target bus number. When the key nibble holds the open value, any access to the 4 KB I/O window starting at 0xC000 turns into one downstream configuration request. Address bits 11:8 of the access become the device number. The low byte becomes the register offset, split into a dword index and byte enables.

The host's own I/O decode is not affected by this block. Any access it does not claim is forwarded on a pass-through port one cycle later, unchanged. While a configuration request is outstanding, the block accepts nothing else. When the downstream response arrives, the block completes the host access. An absent device reads back as all ones in the requested lanes.

Data on both sides is lane-positioned: byte lane k of the 32-bit data carries the byte at address offset k. Access size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.

Top module: `t2cfg_mapper`

## Requirements
- R1: After synchronous reset, both control registers read as zero, `io_ready` is high and `io_rsp_valid`, `pt_valid` and `cfg_req_valid` are low.
- R2: A byte access (size code 0) to 0x0CF8 reaches the key register and one to 0x0CFA reaches the bus register. The write byte is taken from lane addr[1:0] and read data is returned in that lane with zeros elsewhere. `io_rsp_valid` pulses one cycle after acceptance, and write responses carry zero data. Accesses of any other size to these addresses are not claimed.
- R3: The window is claimed only while the key nibble (key register bits 7:4) equals 0xF. Every unclaimed access produces one `pt_valid` pulse one cycle after acceptance, carrying the access's write flag, address, size and data unchanged, and no `io_rsp_valid`.
- R4: A claimed window access produces one `cfg_req_valid` pulse one cycle after acceptance. That pulse carries the bus register value, the function number from key bits 3:1, the device from address bits 11:8, the dword index from address bits 7:2, and the write flag.
- R5: Byte enables cover 1, 2 or 4 lanes, starting at lane addr[1:0] and cut off at lane 3. Write data is passed on unchanged in `cfg_wdata`.
- R6: `io_rsp_valid` pulses in the cycle after `cfg_rsp_valid` is sampled. A read returns the device data in the enabled lanes and zero in the others. A write returns zero.
- R7: When `cfg_rsp_nodev` is high, a read returns 0xFF in every enabled lane and zero in the others.
- R8: Writing zero to the key register closes the window. A window access accepted in the very next cycle passes through, and the key register then reads as zero.
- R9: Only devices 0 to 15 are reachable. `cfg_dev` is 5 bits wide with bit 4 always zero, and device 15 is addressed from 0xCFxx.
- R10: `io_ready` is low from the cycle `cfg_req_valid` pulses until the completion pulse. Requests presented while `io_ready` is low are ignored and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host access request |
| io_write | input | 1 | Host access is a write |
| io_addr | input | 16 | Host I/O address |
| io_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes |
| io_wdata | input | 32 | Lane-positioned write data |
| io_ready | output | 1 | Block can accept a host access |
| io_rsp_valid | output | 1 | Completion of a claimed access |
| io_rdata | output | 32 | Lane-positioned read data |
| pt_valid | output | 1 | Forwarded unclaimed access |
| pt_write | output | 1 | Forwarded write flag |
| pt_addr | output | 16 | Forwarded address |
| pt_size | output | 2 | Forwarded size code |
| pt_wdata | output | 32 | Forwarded write data |
| cfg_req_valid | output | 1 | Configuration request pulse |
| cfg_req_write | output | 1 | Configuration request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_dword | output | 6 | Register dword index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Configuration response |
| cfg_rsp_nodev | input | 1 | No device answered |
| cfg_rsp_data | input | 32 | Configuration read data |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a key register write that closes the window is followed at once by a window access. That access is decoded against the freshly written key, so the bench issues the two back to back and expects a pass-through. In the second, a downstream response can arrive in the same cycle the request pulse appears. The bench's responder answers with latencies 0 to 4 cycles, including zero, and its scoreboard expects the completion exactly one cycle after the response. A host request pushed while the block is busy must leave the key register unchanged, and a later readback judges this.

// File: rtl/t2cfg_pkg.sv
package t2cfg_pkg;
  // Classification of one host access
  typedef enum logic [1:0] {
    KIND_PASS   = 2'd0,
    KIND_KEYREG = 2'd1,
    KIND_BUSREG = 2'd2,
    KIND_WINDOW = 2'd3
  } acc_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } map_state_e;
endpackage

// File: rtl/t2cfg_ctrl_regs.sv
module t2cfg_ctrl_regs #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_we,
  input  logic             bus_we,
  input  logic [REG_W-1:0] wbyte,
  output logic [REG_W-1:0] key_q,
  output logic [REG_W-1:0] bus_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      bus_q <= '0;
    end else begin
      if (key_we) key_q <= wbyte;
      if (bus_we) bus_q <= wbyte;
    end
  end
endmodule

// File: rtl/t2cfg_decode.sv
module t2cfg_decode
  import t2cfg_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_BITS = 12,
  parameter int                DEV_W    = 4,
  parameter int                OFF_W    = 8,
  parameter int                KEY_W    = 4,
  parameter logic [ADDR_W-1:0] EN_PORT  = 16'h0CF8,
  parameter logic [ADDR_W-1:0] FWD_PORT = 16'h0CFA,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
  parameter logic [KEY_W-1:0]  KEY_OPEN = 4'hF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [KEY_W-1:0]  key,
  output acc_kind_e         kind,
  output logic [DEV_W-1:0]  dev,
  output logic [OFF_W-1:0]  off
);
  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

  logic in_window;
  logic is_byte;

  assign in_window = (addr[ADDR_W-1:WIN_BITS] == WIN_TAG);
  assign is_byte   = (size == 2'd0);
  assign dev       = addr[WIN_BITS-1 -: DEV_W];
  assign off       = addr[OFF_W-1:0];

  // Control ports win over the window; the window needs the open key.
  always_comb begin
    if (is_byte && addr == EN_PORT)           kind = KIND_KEYREG;
    else if (is_byte && addr == FWD_PORT)     kind = KIND_BUSREG;
    else if (in_window && key == KEY_OPEN)    kind = KIND_WINDOW;
    else                                      kind = KIND_PASS;
  end
endmodule

// File: rtl/t2cfg_lanes.sv
module t2cfg_lanes #(
  parameter int LANES = 4,
  parameter int LW    = $clog2(LANES)
) (
  input  logic [1:0]         size,
  input  logic [LW-1:0]      lane_off,
  output logic [LANES-1:0]   be,
  input  logic [LANES-1:0]   be_held,
  input  logic               nodev,
  input  logic [8*LANES-1:0] rsp_data,
  output logic [8*LANES-1:0] shaped
);
  logic [7:0] span;

  always_comb begin
    case (size)
      2'd0:    span = 8'd1;
      2'd1:    span = 8'd2;
      default: span = 8'd4;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = (8'(i) >= 8'(lane_off)) && (8'(i) < 8'(lane_off) + span);
    assign shaped[8*i +: 8] = be_held[i] ? (nodev ? 8'hFF : rsp_data[8*i +: 8]) : 8'h00;
  end
endmodule

// File: rtl/t2cfg_mapper.sv
module t2cfg_mapper
  import t2cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 32,
  parameter int                BUS_W     = 8,
  parameter int                KEY_W     = 4,
  parameter int                FUNC_W    = 3,
  parameter int                DEV_W     = 4,
  parameter int                DEV_OUT_W = 5,
  parameter int                OFF_W     = 8,
  parameter int                WIN_BITS  = 12,
  parameter logic [ADDR_W-1:0] EN_PORT   = 16'h0CF8,
  parameter logic [ADDR_W-1:0] FWD_PORT  = 16'h0CFA,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hC000,
  parameter logic [KEY_W-1:0]  KEY_OPEN  = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              io_ready,
  output logic              io_rsp_valid,
  output logic [DATA_W-1:0] io_rdata,
  output logic              pt_valid,
  output logic              pt_write,
  output logic [ADDR_W-1:0] pt_addr,
  output logic [1:0]        pt_size,
  output logic [DATA_W-1:0] pt_wdata,
  output logic              cfg_req_valid,
  output logic              cfg_req_write,
  output logic [BUS_W-1:0]  cfg_bus,
  output logic [DEV_OUT_W-1:0] cfg_dev,
  output logic [FUNC_W-1:0] cfg_func,
  output logic [OFF_W-$clog2(DATA_W/8)-1:0] cfg_dword,
  output logic [DATA_W/8-1:0] cfg_be,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rsp_valid,
  input  logic              cfg_rsp_nodev,
  input  logic [DATA_W-1:0] cfg_rsp_data
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);
  localparam int REG_W = KEY_W + FUNC_W + 1;

  map_state_e       state;
  acc_kind_e        kind;
  logic [DEV_W-1:0] dev;
  logic [OFF_W-1:0] off;
  logic [REG_W-1:0] key_q;
  logic [REG_W-1:0] bus_q;
  logic [REG_W-1:0] wbyte;
  logic [REG_W-1:0] reg_sel;
  logic [LW+2:0]    lane_shift;
  logic [LANES-1:0] be_now;
  logic [LANES-1:0] be_held;
  logic             write_held;
  logic [DATA_W-1:0] shaped;
  logic             accept;
  logic             key_we;
  logic             bus_we;

  assign io_ready   = (state == ST_IDLE);
  assign accept     = io_valid && io_ready;
  assign lane_shift = {io_addr[LW-1:0], 3'b000};
  assign wbyte      = io_wdata[lane_shift +: REG_W];
  assign key_we     = accept && io_write && (kind == KIND_KEYREG);
  assign bus_we     = accept && io_write && (kind == KIND_BUSREG);
  assign reg_sel    = (kind == KIND_KEYREG) ? key_q : bus_q;

  t2cfg_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .DEV_W(DEV_W), .OFF_W(OFF_W),
    .KEY_W(KEY_W), .EN_PORT(EN_PORT), .FWD_PORT(FWD_PORT),
    .WIN_BASE(WIN_BASE), .KEY_OPEN(KEY_OPEN)
  ) u_decode (
    .addr (io_addr),
    .size (io_size),
    .key  (key_q[REG_W-1 -: KEY_W]),
    .kind (kind),
    .dev  (dev),
    .off  (off)
  );

  t2cfg_ctrl_regs #(.REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .key_we (key_we),
    .bus_we (bus_we),
    .wbyte  (wbyte),
    .key_q  (key_q),
    .bus_q  (bus_q)
  );

  t2cfg_lanes #(.LANES(LANES), .LW(LW)) u_lanes (
    .size     (io_size),
    .lane_off (off[LW-1:0]),
    .be       (be_now),
    .be_held  (be_held),
    .nodev    (cfg_rsp_nodev),
    .rsp_data (cfg_rsp_data),
    .shaped   (shaped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      io_rsp_valid  <= 1'b0;
      io_rdata      <= '0;
      pt_valid      <= 1'b0;
      pt_write      <= 1'b0;
      pt_addr       <= '0;
      pt_size       <= '0;
      pt_wdata      <= '0;
      cfg_req_valid <= 1'b0;
      cfg_req_write <= 1'b0;
      cfg_bus       <= '0;
      cfg_dev       <= '0;
      cfg_func      <= '0;
      cfg_dword     <= '0;
      cfg_be        <= '0;
      cfg_wdata     <= '0;
      be_held       <= '0;
      write_held    <= 1'b0;
    end else begin
      io_rsp_valid  <= 1'b0;
      pt_valid      <= 1'b0;
      cfg_req_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            case (kind)
              KIND_KEYREG, KIND_BUSREG: begin
                io_rsp_valid <= 1'b1;
                io_rdata     <= io_write ? '0 : (DATA_W'(reg_sel) << lane_shift);
              end
              KIND_WINDOW: begin
                cfg_req_valid <= 1'b1;
                cfg_req_write <= io_write;
                cfg_bus       <= bus_q[BUS_W-1:0];
                cfg_dev       <= DEV_OUT_W'(dev);
                cfg_func      <= key_q[FUNC_W:1];
                cfg_dword     <= off[OFF_W-1:LW];
                cfg_be        <= be_now;
                cfg_wdata     <= io_wdata;
                be_held       <= be_now;
                write_held    <= io_write;
                state         <= ST_WAIT;
              end
              default: begin
                pt_valid <= 1'b1;
                pt_write <= io_write;
                pt_addr  <= io_addr;
                pt_size  <= io_size;
                pt_wdata <= io_wdata;
              end
            endcase
          end
        end
        ST_WAIT: begin
          if (cfg_rsp_valid) begin
            io_rsp_valid <= 1'b1;
            io_rdata     <= write_held ? '0 : shaped;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/t2cfg_mapper_chk.sv
module t2cfg_mapper_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DEV_W     = 4,
  parameter int                DEV_OUT_W = 5,
  parameter int                OFF_W     = 8,
  parameter int                WIN_BITS  = 12,
  parameter int                LANES     = 4,
  parameter logic [ADDR_W-1:0] EN_PORT   = 16'h0CF8,
  parameter logic [ADDR_W-1:0] FWD_PORT  = 16'h0CFA
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 io_valid,
  input logic                 io_ready,
  input logic [ADDR_W-1:0]    io_addr,
  input logic [1:0]           io_size,
  input logic                 io_rsp_valid,
  input logic                 pt_valid,
  input logic                 cfg_req_valid,
  input logic [DEV_OUT_W-1:0] cfg_dev,
  input logic [OFF_W-$clog2(LANES)-1:0] cfg_dword,
  input logic [LANES-1:0]     cfg_be,
  input logic                 cfg_rsp_valid
);
  localparam int LW = $clog2(LANES);

  // R2: a byte access to either control port completes next cycle
  a_r2_ctrl_reply: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_ready && io_size == 2'd0 && (io_addr == EN_PORT || io_addr == FWD_PORT))
    |=> io_rsp_valid);

  // R3: one access yields at most one kind of outcome per cycle
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pt_valid, cfg_req_valid, io_rsp_valid}));

  // R4: request is a single-cycle pulse
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |=> !cfg_req_valid);

  // R4: dword index comes from the accepted address
  a_r4_dword_from_addr: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> cfg_dword == $past(io_addr[OFF_W-1:LW]));

  // R9: device field reflects address bits of the window, limited to 16 devices
  a_r9_dev_from_addr: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> cfg_dev == DEV_OUT_W'($past(io_addr[WIN_BITS-1 -: DEV_W])));

  // R5: every request enables at least one lane
  a_r5_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> cfg_be != '0);

  // R10: host side blocked while a request is outstanding
  a_r10_blocked: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> !io_ready);

  // R6: response completes the host access on the next cycle
  a_r6_completion: assert property (@(posedge clk) disable iff (rst)
    (cfg_rsp_valid && !io_ready) |=> (io_rsp_valid && io_ready));
endmodule

bind t2cfg_mapper t2cfg_mapper_chk #(
  .ADDR_W(ADDR_W), .DEV_W(DEV_W), .DEV_OUT_W(DEV_OUT_W), .OFF_W(OFF_W),
  .WIN_BITS(WIN_BITS), .LANES(DATA_W/8), .EN_PORT(EN_PORT), .FWD_PORT(FWD_PORT)
) u_chk (.*);

// File: tb/t2cfg_mapper_bench.sv
`timescale 1ns/1ps
module t2cfg_mapper_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        io_valid, io_write;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_ready, io_rsp_valid;
  logic [31:0] io_rdata;
  logic        pt_valid, pt_write;
  logic [15:0] pt_addr;
  logic [1:0]  pt_size;
  logic [31:0] pt_wdata;
  logic        cfg_req_valid, cfg_req_write;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_dword;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_rsp_valid, cfg_rsp_nodev;
  logic [31:0] cfg_rsp_data;

  t2cfg_mapper u_t2cfg_mapper (.*);

  typedef struct packed {
    logic wr; logic [7:0] bus; logic [4:0] dev; logic [2:0] func;
    logic [5:0] dw; logic [3:0] be; logic [31:0] wd;
  } cfgx_t;

  logic [31:0] rsp_q[$];  string rsp_tag[$];
  cfgx_t       cfg_q[$];  string cfg_tag[$];
  logic [50:0] pt_q[$];   string pt_tag[$];

  int   checks = 0, fails = 0;
  bit   done = 0;
  int   rsp_lat = 0;
  logic [7:0] key_m = 8'h00, bus_m = 8'h00;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dev_word(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f, input logic [5:0] w);
    return {b, f, d, 2'b00, w, 8'h5A};
  endfunction

  // Downstream responder: devices 12 and up are absent
  initial begin
    cfg_rsp_valid = 0; cfg_rsp_nodev = 0; cfg_rsp_data = '0;
    forever begin
      @(negedge clk);
      cfg_rsp_valid = 0;
      if (cfg_req_valid) begin
        logic [31:0] d;
        logic        nd;
        d  = dev_word(cfg_bus, cfg_dev, cfg_func, cfg_dword);
        nd = (cfg_dev >= 5'd12);
        repeat (rsp_lat) @(negedge clk);
        cfg_rsp_valid = 1; cfg_rsp_nodev = nd; cfg_rsp_data = d;
      end
    end
  end

  // Monitor: pops and compares scoreboard entries
  initial begin
    forever begin
      @(negedge clk);
      if (io_rsp_valid) begin
        if (rsp_q.size() == 0) check(0, "R6 unexpected completion", 64'(io_rdata), 0);
        else begin
          logic [31:0] e; string t;
          e = rsp_q.pop_front(); t = rsp_tag.pop_front();
          check(io_rdata == e, t, 64'(io_rdata), 64'(e));
        end
      end
      if (pt_valid) begin
        if (pt_q.size() == 0) check(0, "R3 unexpected pass-through", 64'(pt_addr), 0);
        else begin
          logic [50:0] e; string t;
          e = pt_q.pop_front(); t = pt_tag.pop_front();
          check({pt_write, pt_addr, pt_size, pt_wdata} == e, t,
                64'({pt_write, pt_addr, pt_size, pt_wdata}), 64'(e));
        end
      end
      if (cfg_req_valid) begin
        cfgx_t a;
        a = {cfg_req_write, cfg_bus, cfg_dev, cfg_func, cfg_dword, cfg_be, cfg_wdata};
        if (cfg_q.size() == 0) check(0, "R4 unexpected request", 64'(a), 0);
        else begin
          cfgx_t e; string t;
          e = cfg_q.pop_front(); t = cfg_tag.pop_front();
          check(a == e, t, 64'(a), 64'(e));
        end
      end
    end
  end

  task automatic issue(input logic wr, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    while (!io_ready) @(negedge clk);
    io_valid = 1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
    @(posedge clk);
    #1 io_valid = 0;
  endtask

  task automatic ctrl_wr(input logic [15:0] a, input logic [7:0] v, input string tag);
    rsp_q.push_back(32'h0); rsp_tag.push_back(tag);
    issue(1'b1, a, 2'd0, 32'(v) << (8 * a[1:0]));
    if (a == 16'h0CF8) key_m = v;
    if (a == 16'h0CFA) bus_m = v;
  endtask

  task automatic ctrl_rd(input logic [15:0] a, input string tag);
    logic [7:0] v;
    v = (a == 16'h0CF8) ? key_m : bus_m;
    rsp_q.push_back(32'(v) << (8 * a[1:0])); rsp_tag.push_back(tag);
    issue(1'b0, a, 2'd0, 32'h0);
  endtask

  task automatic pass_acc(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag);
    pt_q.push_back({wr, a, sz, wd}); pt_tag.push_back(tag);
    issue(wr, a, sz, wd);
  endtask

  task automatic win_acc(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input int lat, input string tag);
    logic [3:0]  be;
    logic [31:0] src, exp_rd;
    logic [4:0]  d;
    int span;
    span = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int i = 0; i < 4; i++) be[i] = (i >= int'(a[1:0])) && (i < int'(a[1:0]) + span);
    d   = {1'b0, a[11:8]};
    src = (d >= 5'd12) ? 32'hFFFF_FFFF : dev_word(bus_m, d, key_m[3:1], a[7:2]);
    for (int i = 0; i < 4; i++) exp_rd[8*i +: 8] = be[i] ? src[8*i +: 8] : 8'h00;
    if (wr) exp_rd = 32'h0;
    cfg_q.push_back({wr, bus_m, d, key_m[3:1], a[7:2], be, wd}); cfg_tag.push_back(tag);
    rsp_q.push_back(exp_rd); rsp_tag.push_back(tag);
    rsp_lat = lat;
    issue(wr, a, sz, wd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; io_valid = 0; io_write = 0; io_addr = '0; io_size = '0; io_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(io_ready == 1'b1, "R1 ready after reset", 64'(io_ready), 1);
    check({io_rsp_valid, pt_valid, cfg_req_valid} == 3'b000, "R1 outputs idle",
          64'({io_rsp_valid, pt_valid, cfg_req_valid}), 0);
    ctrl_rd(16'h0CF8, "R1 key register reset");
    ctrl_rd(16'h0CFA, "R1 bus register reset");
    pass_acc(1'b0, 16'hC300, 2'd2, 32'h0, "R3 window closed at reset");

    ctrl_wr(16'h0CFA, 8'h05, "R2 bus register write");
    ctrl_rd(16'h0CFA, "R2 bus register readback lane 2");
    ctrl_wr(16'h0CF8, 8'h34, "R2 key register write");
    ctrl_rd(16'h0CF8, "R2 key register readback");
    pass_acc(1'b0, 16'hC300, 2'd2, 32'h0, "R3 wrong key leaves window unclaimed");
    pass_acc(1'b0, 16'h0CF8, 2'd2, 32'h0, "R2 dword at key port not claimed");
    ctrl_wr(16'h0CF8, 8'hF4, "R2 open key with function 2");

    win_acc(1'b0, 16'hC300, 2'd2, 32'h0, 0, "R4 dword read, zero latency");
    win_acc(1'b0, 16'hC305, 2'd0, 32'h0, 1, "R5 byte read lane 1");
    win_acc(1'b0, 16'hC70A, 2'd1, 32'h0, 3, "R5 word read upper half");
    win_acc(1'b0, 16'hCD04, 2'd1, 32'h0, 2, "R7 absent device ones in lanes");
    win_acc(1'b1, 16'hC212, 2'd0, 32'h00AB_0000, 1, "R5 byte write lane 2");
    win_acc(1'b1, 16'hC540, 2'd2, 32'hDEAD_BEEF, 0, "R6 dword write completion");
    pass_acc(1'b1, 16'h0080, 2'd0, 32'h0000_0011, "R3 unrelated address forwarded");
    win_acc(1'b0, 16'hCFFC, 2'd2, 32'h0, 1, "R9 device 15 reachable");
    win_acc(1'b0, 16'hC60D, 2'd2, 32'h0, 2, "R5 misaligned dword cut at lane 3");

    // R10: request presented while busy must be ignored
    win_acc(1'b0, 16'hC104, 2'd2, 32'h0, 4, "R10 outstanding read");
    @(negedge clk);
    io_valid = 1; io_write = 1; io_addr = 16'h0CF8; io_size = 2'd0; io_wdata = 32'h0;
    @(posedge clk);
    #1 io_valid = 0;
    ctrl_rd(16'h0CF8, "R10 key unchanged by ignored request");

    ctrl_wr(16'h0CFA, 8'hFE, "R4 new bus number");
    win_acc(1'b0, 16'hC808, 2'd2, 32'h0, 1, "R4 bus taken from bus register");

    // R8: close and access back to back
    ctrl_wr(16'h0CF8, 8'h00, "R8 close window");
    pass_acc(1'b0, 16'hC300, 2'd2, 32'h0, "R8 access right after close passes");
    ctrl_rd(16'h0CF8, "R8 key reads zero");

    for (int i = 0; i < 50 && (rsp_q.size() + pt_q.size() + cfg_q.size()) != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rsp_q.size() == 0, "R6 all completions seen", 64'(rsp_q.size()), 0);
    check(pt_q.size() == 0, "R3 all pass-throughs seen", 64'(pt_q.size()), 0);
    check(cfg_q.size() == 0, "R4 all requests seen", 64'(cfg_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule